// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the slave-side command engine of a serial nonvolatile memory reached over SPI. A host selects the device with an active-low chip select, clocks in an 8-bit opcode most significant bit first, and then, depending on the opcode, a 16-bit address, data bytes to store, or clock cycles that return memory or status bytes. The storage array sits outside the block. The block reaches it through a byte-wide port with an address, a read-data input, a write-data output and a write strobe.

Writes are guarded in two ways. A write-enable latch must first be armed by a dedicated command. An accepted write or status write then starts an internal write cycle of programmable length, counted in system clocks. For the whole of that cycle every command except a status read is discarded. Write data is collected into a page buffer as it arrives and is swept into the array during the write cycle. The serial output goes to a pad through a data bit and an output-enable bit. The enable is held low whenever no read data is being shifted out.

The serial pins are sampled by the system clock through two-stage synchronizers. The serial clock must therefore stay below roughly one eighth of the system clock rate.

Top module: `spiMemCtrl`

## Requirements
- R1: SPI modes 0 and 3 both work. SI is captured on the rising serial-clock edge and the output bit changes only after a falling edge, whatever the idle clock level. A given transfer returns the same bytes in either mode.
- R2: The first 8 bits after chip select falls form the opcode, MSB first. The opcodes are 0x06 arm writes, 0x04 disarm writes, 0x05 read status, 0x01 write status, 0x03 read, and 0x02 write. Any other opcode is ignored until chip select rises: the output enable stays low and no state changes.
- R3: After reset the status byte reads 0x00.
- R4: A write (0x02) or status write (0x01) issued while the write-enable latch is clear is ignored. No array write takes place, no busy period starts, and the status stays the same.
- R5: The arm command sets the write-enable latch only when chip select rises right after its 8 opcode bits. If any extra clock follows the opcode, the command is voided. The disarm command clears the latch in the same way.
- R6: The status byte is laid out as follows: bit 0 is busy, bit 1 is the write-enable latch, and bits 7:2 hold a field loaded by the status write (bits 1:0 of the written byte are discarded). A status read streams the live status byte again for every further byte clocked.
- R7: While busy, every opcode except 0x05 is ignored. This includes reads, which leave the output enable low.
- R8: A read takes a 16-bit address, MSB first. It returns bytes MSB first, increments the address after each byte, and wraps from 0xFFFF to 0x0000.
- R9: A write takes a 16-bit address. Data bytes go to successive locations, but only the low 6 address bits advance, so the bytes wrap within a 64-byte page. Locations outside that page are never written.
- R10: A busy period starts only when chip select rises after one or more whole data bytes of an armed write or status write. A partial final byte cancels the whole command and leaves the write-enable latch set.
- R11: The busy period lasts WRITE_CYCLES system clocks. Array writes happen only while busy. When the period ends, both the busy bit and the write-enable latch clear.
- R12: The output enable is low whenever chip select is high. It is also low when chip select is low but no read or status data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| soData | output | 1 | Serial data bit toward the pad |
| soOe | output | 1 | Output enable for the serial data pad (low means high impedance) |
| memAddr | output | 16 | Array address, used for reads and for page commits |
| memRdData | input | 8 | Array read data for memAddr |
| memWrData | output | 8 | Array write data |
| memWe | output | 1 | Array write strobe, one byte per clock |

## Verification
Several rules are checked on every cycle by properties: array writes happen only inside a busy period; a busy period can only begin while the write-enable latch is set; the latch is found clear whenever busy falls; and the latch never rises while busy. Opcode decode, address wrap in both directions, rejection of partial bytes, voiding of an arm command followed by extra clocks, the status field layout and the equality of modes 0 and 3 are sequence behaviours. Those are shown only by the bench's scenarios, which compare returned bytes, output-enable activity and every array write against a behavioural memory model.

// File: rtl/spiMemPkg.sv
package spiMemPkg;
  localparam int ADDR_W = 16;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_WDATA, PH_SDATA,
    PH_RDOUT, PH_STOUT, PH_ARMED, PH_SKIP
  } phase_e;

  // Strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic       shiftIn;
    logic       addrHi;
    logic       addrLo;
    logic       rdInc;
    logic       bufWrite;
    logic       bufClear;
    logic       outLoadMem;
    logic       outLoadStat;
    logic       outShift;
    logic       userCapture;
    logic       userCommit;
    logic       commitEn;
    logic [7:0] commitIdx;
  } strobe_t;
endpackage

// File: rtl/spiMemControl.sv
module spiMemControl
  import spiMemPkg::*;
#(
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       si,
  input  logic [7:0] rxByte,
  output logic       siS,
  output strobe_t    strb,
  output logic       busy,
  output logic       wel,
  output logic       soActive
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [2:0] sckPipe, csPipe;
  logic [1:0] siPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      siPipe  <= '0;
    end else begin
      sckPipe <= {sckPipe[1:0], sck};
      csPipe  <= {csPipe[1:0], csN};
      siPipe  <= {siPipe[0], si};
    end
  end

  logic csActive, csFall, csRise, sckRise, sckFall;
  assign siS      = siPipe[1];
  assign csActive = ~csPipe[1];
  assign csFall   = ~csPipe[1] & csPipe[2];
  assign csRise   = csPipe[1] & ~csPipe[2];
  assign sckRise  = sckPipe[1] & ~sckPipe[2];
  assign sckFall  = ~sckPipe[1] & sckPipe[2];

  phase_e           phase, phaseN;
  logic [2:0]       bitIdx, bitIdxN, outBit, outBitN;
  logic             addrSecond, addrSecondN, haveByte, haveByteN;
  logic             outStarted, outStartedN, welN, busyN;
  logic [7:0]       opReg, opRegN;
  logic [CNT_W-1:0] busyCnt, busyCntN;

  always_comb begin
    strb        = '0;
    phaseN      = phase;
    bitIdxN     = bitIdx;
    outBitN     = outBit;
    addrSecondN = addrSecond;
    haveByteN   = haveByte;
    outStartedN = outStarted;
    opRegN      = opReg;
    welN        = wel;
    busyN       = busy;
    busyCntN    = busyCnt;

    // internal write cycle: sweep the page buffer, then release
    if (busy) begin
      if (busyCnt == CNT_W'(WRITE_CYCLES - 1)) begin
        busyN = 1'b0;
        welN  = 1'b0;
      end else begin
        busyCntN = busyCnt + 1'b1;
      end
      if (int'(busyCnt) < PAGE_BYTES) begin
        strb.commitEn  = 1'b1;
        strb.commitIdx = 8'(busyCnt);
      end
    end

    if (csFall) begin
      phaseN        = PH_CMD;
      bitIdxN       = '0;
      outBitN       = '0;
      outStartedN   = 1'b0;
      addrSecondN   = 1'b0;
      haveByteN     = 1'b0;
      strb.bufClear = ~busy;
    end else if (csRise) begin
      case (phase)
        PH_ARMED: begin
          if (opReg == OP_WREN) welN = 1'b1;
          else if (opReg == OP_WRDI) welN = 1'b0;
        end
        PH_WDATA: begin
          if (haveByte && bitIdx == 3'd0) begin
            busyN    = 1'b1;
            busyCntN = '0;
          end
        end
        PH_SDATA: begin
          if (haveByte && bitIdx == 3'd0) begin
            busyN           = 1'b1;
            busyCntN        = '0;
            strb.userCommit = 1'b1;
          end
        end
        default: ;
      endcase
      phaseN = PH_IDLE;
    end else if (csActive && sckRise) begin
      strb.shiftIn = 1'b1;
      bitIdxN      = bitIdx + 3'd1;
      if (phase == PH_ARMED) begin
        phaseN = PH_SKIP;
      end else if (bitIdx == 3'd7) begin
        case (phase)
          PH_CMD: begin
            opRegN = rxByte;
            if (busy && rxByte != OP_RDSR) phaseN = PH_SKIP;
            else begin
              case (rxByte)
                OP_WREN, OP_WRDI: phaseN = PH_ARMED;
                OP_RDSR:          phaseN = PH_STOUT;
                OP_READ:          phaseN = PH_ADDR;
                OP_WRITE:         phaseN = wel ? PH_ADDR : PH_SKIP;
                OP_WRSR:          phaseN = wel ? PH_SDATA : PH_SKIP;
                default:          phaseN = PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            if (!addrSecond) begin
              strb.addrHi = 1'b1;
              addrSecondN = 1'b1;
            end else begin
              strb.addrLo = 1'b1;
              phaseN      = (opReg == OP_READ) ? PH_RDOUT : PH_WDATA;
            end
          end
          PH_WDATA: begin
            strb.bufWrite = 1'b1;
            haveByteN     = 1'b1;
          end
          PH_SDATA: begin
            strb.userCapture = 1'b1;
            haveByteN        = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (csActive && sckFall && (phase == PH_RDOUT || phase == PH_STOUT)) begin
      outStartedN = 1'b1;
      outBitN     = outBit + 3'd1;
      if (outBit == 3'd0) begin
        if (phase == PH_RDOUT) begin
          strb.outLoadMem = 1'b1;
          strb.rdInc      = 1'b1;
        end else begin
          strb.outLoadStat = 1'b1;
        end
      end else begin
        strb.outShift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      bitIdx     <= '0;
      outBit     <= '0;
      addrSecond <= 1'b0;
      haveByte   <= 1'b0;
      outStarted <= 1'b0;
      opReg      <= '0;
      wel        <= 1'b0;
      busy       <= 1'b0;
      busyCnt    <= '0;
    end else begin
      phase      <= phaseN;
      bitIdx     <= bitIdxN;
      outBit     <= outBitN;
      addrSecond <= addrSecondN;
      haveByte   <= haveByteN;
      outStarted <= outStartedN;
      opReg      <= opRegN;
      wel        <= welN;
      busy       <= busyN;
      busyCnt    <= busyCntN;
    end
  end

  assign soActive = outStarted && (phase == PH_RDOUT || phase == PH_STOUT);
endmodule

// File: rtl/spiMemDatapath.sv
module spiMemDatapath
  import spiMemPkg::*;
#(
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              siS,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic              wel,
  input  logic [7:0]        memRdData,
  output logic [7:0]        rxByte,
  output logic              soBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              memWe
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [6:0]        rxShift;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        outReg;
  logic [5:0]        userBits, userPend;
  logic [PAGE_BYTES-1:0] dirty;
  logic [7:0]        pageBuf [PAGE_BYTES];
  logic [PAGE_W-1:0] commitOff, fillOff;
  logic [7:0]        statusByte;
  logic              unusedIdx;

  assign rxByte     = {rxShift, siS};
  assign commitOff  = strb.commitIdx[PAGE_W-1:0];
  assign fillOff    = addr[PAGE_W-1:0];
  assign statusByte = {userBits, wel, busy};
  assign unusedIdx  = ^strb.commitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      addr     <= '0;
      outReg   <= '0;
      userBits <= '0;
      userPend <= '0;
      dirty    <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= rxByte[6:0];
      if (strb.addrHi)  addr[ADDR_W-1 -: 8] <= rxByte;
      if (strb.addrLo)  addr[7:0] <= rxByte;
      if (strb.rdInc)   addr <= addr + 1'b1;
      if (strb.bufWrite) begin
        dirty[fillOff]        <= 1'b1;
        addr[PAGE_W-1:0]      <= fillOff + 1'b1;
      end
      if (strb.bufClear)    dirty <= '0;
      if (strb.outLoadMem)  outReg <= memRdData;
      if (strb.outLoadStat) outReg <= statusByte;
      if (strb.outShift)    outReg <= {outReg[6:0], 1'b0};
      if (strb.userCapture) userPend <= rxByte[7:2];
      if (strb.userCommit)  userBits <= userPend;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.bufWrite) pageBuf[fillOff] <= rxByte;
  end

  assign soBit     = outReg[7];
  assign memAddr   = strb.commitEn ? {addr[ADDR_W-1:PAGE_W], commitOff} : addr;
  assign memWe     = strb.commitEn & dirty[commitOff];
  assign memWrData = pageBuf[commitOff];
endmodule

// File: rtl/spiMemCtrl.sv
module spiMemCtrl
  import spiMemPkg::*;
#(
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sck,
  input  logic        csN,
  input  logic        si,
  output logic        soData,
  output logic        soOe,
  output logic [15:0] memAddr,
  input  logic [7:0]  memRdData,
  output logic [7:0]  memWrData,
  output logic        memWe
);
  strobe_t    strb;
  logic       siS, busy, wel, soActive, soBit;
  logic [7:0] rxByte;

  spiMemControl #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_control (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .rxByte(rxByte),
    .siS(siS), .strb(strb), .busy(busy), .wel(wel), .soActive(soActive)
  );

  spiMemDatapath #(.PAGE_BYTES(PAGE_BYTES)) u_datapath (
    .clk(clk), .rstN(rstN), .siS(siS), .strb(strb), .busy(busy), .wel(wel),
    .memRdData(memRdData), .rxByte(rxByte), .soBit(soBit), .memAddr(memAddr),
    .memWrData(memWrData), .memWe(memWe)
  );

  assign soOe   = soActive & ~csN;
  assign soData = soBit;
endmodule

// File: rtl/spiMemCtrl_chk.sv
module spiMemCtrl_chk (
  input logic clk,
  input logic rstN,
  input logic memWe,
  input logic busy,
  input logic wel
);
  AST_WE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R11
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> wel); // R4
  AST_WEL_CLEAR_AT_READY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel); // R11
  AST_NO_ARM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !busy); // R7
endmodule

bind spiMemCtrl spiMemCtrl_chk u_chk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .busy(busy), .wel(wel)
);

// File: tb/spiMemCtrl_bench.sv
module spiMemCtrl_bench;
  localparam int PAGE = 64;
  localparam int WCYC = 200;
  localparam int H    = 4;

  logic        clk = 1'b0, rstN = 1'b0, sck = 1'b0, csN = 1'b1, si = 1'b0;
  logic        soData, soOe, memWe;
  logic [15:0] memAddr;
  logic [7:0]  memRdData = 8'hFF, memWrData;
  int          total = 0, bad = 0, oeCount = 0;
  logic [7:0]  mem    [int];
  logic [7:0]  expMem [int];
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];

  always #5 clk = ~clk;

  spiMemCtrl #(.PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) u_spiMemCtrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .soData(soData), .soOe(soOe),
    .memAddr(memAddr), .memRdData(memRdData), .memWrData(memWrData), .memWe(memWe)
  );

  function automatic logic [7:0] peekMem(input int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] peekExp(input int a);
    return expMem.exists(a) ? expMem[a] : 8'hFF;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // array model and per-clock comparison against the behavioural model
  always @(negedge clk) begin
    memRdData <= peekMem(int'(memAddr));
    if (rstN && memWe) begin
      total++;
      if (memWrData !== peekExp(int'(memAddr))) begin
        bad++;
        $display("FAIL R9 write @%h: actual=%h expected=%h", memAddr, memWrData, peekExp(int'(memAddr)));
      end
      mem[int'(memAddr)] = memWrData;
    end
    if (csN && soOe) begin
      total++; bad++;
      $display("FAIL R12 oe while deselected: actual=1 expected=0");
    end
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  // one transaction: txq bytes, then nRead bytes clocked with SI low, then extra bits
  task automatic xfer(input bit m3, input int nRead, input int extraBits);
    rxq.delete();
    oeCount = 0;
    sck = m3; half();
    csN = 1'b0; half();
    for (int b = 0; b < txq.size() + nRead; b++) begin
      logic [7:0] outB;
      logic [7:0] inB;
      outB = (b < txq.size()) ? txq[b] : 8'h00;
      inB  = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        sck = 1'b0; si = outB[i]; half();
        inB[i] = soData;
        if (soOe) oeCount++;
        sck = 1'b1; half();
      end
      if (b >= txq.size()) rxq.push_back(inB);
    end
    for (int i = 0; i < extraBits; i++) begin
      sck = 1'b0; si = 1'b1; half(); sck = 1'b1; half();
    end
    if (!m3) begin sck = 1'b0; half(); end
    csN = 1'b1; half(); half();
  endtask

  task automatic op1(input bit m3, input logic [7:0] op);
    txq.delete(); txq.push_back(op); xfer(m3, 0, 0);
  endtask
  task automatic rdStatus(input bit m3, input int n);
    txq.delete(); txq.push_back(8'h05); xfer(m3, n, 0);
  endtask
  task automatic rdMem(input bit m3, input logic [15:0] a, input int n);
    txq.delete(); txq.push_back(8'h03); txq.push_back(a[15:8]); txq.push_back(a[7:0]);
    xfer(m3, n, 0);
  endtask
  task automatic wrHeader(input logic [15:0] a);
    txq.delete(); txq.push_back(8'h02); txq.push_back(a[15:8]); txq.push_back(a[7:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem[32'h0000FFFF] = 8'h5C; expMem[32'h0000FFFF] = 8'h5C;
    mem[32'h00000000] = 8'h3D; expMem[32'h00000000] = 8'h3D;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3 reset state
    chk("R12", "oe after reset", {7'd0, soOe}, 8'h00);
    rdStatus(1'b0, 1);
    chk("R3", "status after reset", rxq[0], 8'h00);

    // R4 write without arming is rejected
    wrHeader(16'h0100); txq.push_back(8'hA5); xfer(1'b1, 0, 0);
    rdStatus(1'b0, 1);
    chk("R4", "status after unarmed write", rxq[0], 8'h00);
    rdMem(1'b0, 16'h0100, 1);
    chk("R4", "array after unarmed write", rxq[0], 8'hFF);

    // R5 arm, then voided arm with trailing clocks, then disarm
    op1(1'b0, 8'h06);
    rdStatus(1'b1, 1);
    chk("R5", "status after arm", rxq[0], 8'h02);
    op1(1'b1, 8'h04);
    rdStatus(1'b0, 1);
    chk("R5", "status after disarm", rxq[0], 8'h00);
    txq.delete(); txq.push_back(8'h06); xfer(1'b0, 1, 0);
    rdStatus(1'b0, 1);
    chk("R5", "arm voided by extra clocks", rxq[0], 8'h00);

    // R10 write, R6 live status polling, R11 busy length and release
    op1(1'b0, 8'h06);
    wrHeader(16'h0100); txq.push_back(8'hA1); txq.push_back(8'hB2); txq.push_back(8'hC3);
    expMem[32'h100] = 8'hA1; expMem[32'h101] = 8'hB2; expMem[32'h102] = 8'hC3;
    xfer(1'b1, 0, 0);
    rdStatus(1'b1, 4);
    chk("R6", "status byte 1 while busy", rxq[0], 8'h03);
    chk("R11", "status byte 2 still busy", rxq[1], 8'h03);
    chk("R11", "status byte 4 after busy", rxq[3], 8'h00);

    // R8 and R1: read back in both modes
    rdMem(1'b0, 16'h0100, 3);
    chk("R8", "read mode0 byte0", rxq[0], 8'hA1);
    chk("R8", "read mode0 byte1", rxq[1], 8'hB2);
    chk("R8", "read mode0 byte2", rxq[2], 8'hC3);
    rdMem(1'b1, 16'h0101, 2);
    chk("R1", "read mode3 byte0", rxq[0], 8'hB2);
    chk("R1", "read mode3 byte1", rxq[1], 8'hC3);

    // R8 wrap at top of array
    rdMem(1'b1, 16'hFFFF, 2);
    chk("R8", "read at 0xFFFF", rxq[0], 8'h5C);
    chk("R8", "read wrapped to 0x0000", rxq[1], 8'h3D);

    // R9 page wrap
    op1(1'b1, 8'h06);
    wrHeader(16'h023E);
    txq.push_back(8'h11); txq.push_back(8'h22); txq.push_back(8'h33); txq.push_back(8'h44);
    expMem[32'h23E] = 8'h11; expMem[32'h23F] = 8'h22;
    expMem[32'h200] = 8'h33; expMem[32'h201] = 8'h44;
    xfer(1'b0, 0, 0);
    // R7 a read issued while busy is ignored
    rdMem(1'b0, 16'h0100, 3);
    chk("R7", "oe during busy read", 8'(oeCount), 8'h00);
    rdStatus(1'b0, 1);
    chk("R11", "ready after page write", rxq[0], 8'h00);
    rdMem(1'b1, 16'h0200, 2);
    chk("R9", "page wrap byte at 0x0200", rxq[0], 8'h33);
    chk("R9", "page wrap byte at 0x0201", rxq[1], 8'h44);
    rdMem(1'b1, 16'h023E, 3);
    chk("R9", "byte at 0x023E", rxq[0], 8'h11);
    chk("R9", "byte at 0x023F", rxq[1], 8'h22);
    chk("R9", "next page untouched", rxq[2], 8'hFF);

    // R10 partial final byte cancels the write
    op1(1'b0, 8'h06);
    wrHeader(16'h0400); txq.push_back(8'h99); xfer(1'b0, 0, 3);
    rdStatus(1'b0, 1);
    chk("R10", "status after partial byte", rxq[0], 8'h02);
    rdMem(1'b0, 16'h0400, 1);
    chk("R10", "array after partial byte", rxq[0], 8'hFF);

    // R6 status write field, bits 1:0 discarded
    txq.delete(); txq.push_back(8'h01); txq.push_back(8'hFF); xfer(1'b1, 0, 0);
    rdStatus(1'b1, 4);
    chk("R6", "status during status write", rxq[0], 8'hFF);
    chk("R6", "status after status write", rxq[3], 8'hFC);

    // R4 unarmed status write ignored
    txq.delete(); txq.push_back(8'h01); txq.push_back(8'h00); xfer(1'b0, 0, 0);
    rdStatus(1'b0, 1);
    chk("R4", "status after unarmed status write", rxq[0], 8'hFC);

    // R2 unknown opcode
    txq.delete(); txq.push_back(8'hAB); xfer(1'b0, 2, 0);
    chk("R2", "oe for unknown opcode", 8'(oeCount), 8'h00);
    rdStatus(1'b1, 1);
    chk("R2", "status after unknown opcode", rxq[0], 8'hFC);

    // R12 status read drives oe only in data phase
    rdStatus(1'b0, 1);
    chk("R12", "oe bits in one status byte", 8'(oeCount), 8'h08);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule